// File: doc/BRIEF.md
# Data-Edge Phase Detector with Mode Select

This block produces the pump-up and pump-down levels that steer a clock-recovery loop onto a sparse, non-periodic stream of read data. Time is modelled by a fast sampling clock. Each recovered bit cell is split into `2*HALF_SLOTS` equal slots, and an internal phase counter walks through them. The recovered clock is high for the first half of the cell and low for the second half. Its rising edge falls on slot 0 and its falling edge on slot `HALF_SLOTS`.

Raw data passes through a two-flop synchroniser. Only its rising transitions count as timing events. On such an event, pump-up goes high and stays high until the next rising clock edge, so its width carries the phase error. Pump-down is a fixed half-cycle reference. It spans from the next falling clock edge to the rising edge that follows, and appears only when a data edge has occurred. A read-enable select chooses the source of the pump outputs: this data detector, or the up/down requests of an external reference phase/frequency detector.

A signed per-cell error, equal to pump-up slots minus pump-down slots, is reported once per cell. It is a one-sample stream with `err_valid` as its valid flag and no ready. A closed loop cannot wait, so there is no back-pressure: a consumer must take the value in the sample where it is valid, or the value is lost.

Top module: `pd_data_phase_det`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn` and `err_valid` are 0, and `rclk` is 1 because the phase counter sits at slot 0.
- R2: `rclk` is 1 during slots 0 to `HALF_SLOTS-1` and 0 during slots `HALF_SLOTS` to `2*HALF_SLOTS-1`, giving exactly `HALF_SLOTS` high samples per cell.
- R3: Suppose rising raw data is first seen after synchronisation in slot p, which is two sampling clocks after the raw input is sampled high. The detector's up level is then high from slot p through slot `2*HALF_SLOTS-1`, for a width of `2*HALF_SLOTS-p` slots. Both pump outputs are registered and lag the internal level by one sampling clock.
- R4: A falling transition of the raw data produces no pump-up or pump-down slot.
- R5: Each data edge arms one pump-down pulse of exactly `HALF_SLOTS` slots, covering slots `HALF_SLOTS` to `2*HALF_SLOTS-1`. If p ≤ `HALF_SLOTS`, the pulse lands in the same cell. If p > `HALF_SLOTS`, it lands in the next cell.
- R6: A cell with no data edge and nothing armed produces neither pulse, and its error is 0.
- R7: `err_valid` is 1 for exactly one sample, at slot 0, when `rd_en` was high at the last slot of the cell. `err_value` is the two's-complement count of up slots minus down slots in the cell just ended. An edge at p = `HALF_SLOTS` gives 0, and an edge at p < `HALF_SLOTS` gives `HALF_SLOTS-p`.
- R8: While `rd_en` is 0, `pump_up` and `pump_dn` copy `ref_up` and `ref_dn` with one sampling clock of latency, data edges have no effect on them, and `err_valid` stays 0.
- R9: Several data edges that arm before the same falling edge yield a single pump-down pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_data | input | 1 | Asynchronous raw read data |
| rd_en | input | 1 | 1 selects the data detector, 0 selects the reference detector |
| ref_up | input | 1 | Up request from the reference phase/frequency detector |
| ref_dn | input | 1 | Down request from the reference phase/frequency detector |
| pump_up | output | 1 | Pump-up level |
| pump_dn | output | 1 | Pump-down level |
| rclk | output | 1 | Recovered clock level (high in the first half of the cell) |
| err_valid | output | 1 | Valid flag of the per-cell error stream |
| err_value | output | ERR_W | Signed per-cell error, up slots minus down slots |

## Verification
The bench places data edges at chosen slots on both sides of the mid-cell point. A shaper that closed pump-up at the falling edge, or that fired pump-down immediately for a late edge, would produce wrong slot counts and a wrong error sign. It also makes two edges arm before one falling edge, where a design that queued pulses would emit a second pump-down in the following idle cell. It holds the data high across a cell boundary and drops it mid-cell, where a detector that reacted to both transitions would emit stray pulses. Finally, it switches to reference mode while data edges keep arriving: a wrong multiplexer would leak detector pulses or a valid error.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  // Strobes decoded from the bit-cell phase counter.
  typedef struct packed {
    logic fall;   // slot at which the recovered clock goes low
    logic last;   // final slot of the cell
  } pd_tick_t;
endpackage

// File: rtl/pd_phase_gen.sv
`timescale 1ns/1ps
module pd_phase_gen
  import pd_pkg::*;
#(
  parameter int HALF_SLOTS = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  output pd_tick_t tick,
  output logic     rclk
);
  localparam int CELL = 2 * HALF_SLOTS;
  localparam int PW   = $clog2(CELL);
  localparam logic [PW-1:0] LAST_SLOT = PW'(CELL - 1);
  localparam logic [PW-1:0] FALL_SLOT = PW'(HALF_SLOTS);

  logic [PW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  slot_q <= '0;
    else if (slot_q == LAST_SLOT) slot_q <= '0;
    else                         slot_q <= slot_q + PW'(1);
  end

  // Both clock edges shape pulses, so the level is an exact half split.
  assign rclk      = (slot_q < FALL_SLOT);
  assign tick.fall = (slot_q == FALL_SLOT);
  assign tick.last = (slot_q == LAST_SLOT);

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST_SLOT) else $error("slot counter out of range");
endmodule

// File: rtl/pd_edge_sync.sv
`timescale 1ns/1ps
module pd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  // Only low-to-high transitions are timing events.
  assign rise = chain_q[STAGES-1] & ~prev_q;

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise) else $error("edge strobe longer than one slot");
endmodule

// File: rtl/pd_pulse_shaper.sv
`timescale 1ns/1ps
module pd_pulse_shaper
  import pd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     data_rise,
  input  pd_tick_t tick,
  input  logic     rclk,
  output logic     up_now,
  output logic     dn_now
);
  logic up_hold_q;   // up level continues into following slots
  logic dn_arm_q;    // a reference pulse is owed at the next falling edge
  logic dn_run_q;    // reference pulse continues into following slots

  // Up: from the data edge until the cell closes at the next rising edge.
  assign up_now = data_rise | up_hold_q;
  // Down: starts only on the falling edge, runs to the next rising edge.
  assign dn_now = (tick.fall & (dn_arm_q | data_rise)) | dn_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_hold_q <= 1'b0;
      dn_arm_q  <= 1'b0;
      dn_run_q  <= 1'b0;
    end else begin
      up_hold_q <= up_now & ~tick.last;
      dn_run_q  <= dn_now & ~tick.last;
      // Edges that arm before one falling edge merge into one pulse.
      dn_arm_q  <= (dn_arm_q | data_rise) & ~tick.fall;
    end
  end

  assert_dn_low_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_now |-> !rclk) else $error("pump-down outside low half of cell");
endmodule

// File: rtl/pd_error_acc.sv
`timescale 1ns/1ps
module pd_error_acc #(
  parameter int HALF_SLOTS = 4,
  parameter int ERR_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_now,
  input  logic                    dn_now,
  input  logic                    cell_last,
  input  logic                    rd_en,
  output logic                    err_valid,
  output logic signed [ERR_W-1:0] err_value
);
  localparam logic signed [ERR_W-1:0] STEP_UP = ERR_W'(1);
  localparam logic signed [ERR_W-1:0] STEP_DN = -STEP_UP;

  logic signed [ERR_W-1:0] acc_q, step, sum;

  always_comb begin
    step = '0;
    if (up_now && !dn_now)      step = STEP_UP;
    else if (dn_now && !up_now) step = STEP_DN;
    sum = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      err_valid <= 1'b0;
      err_value <= '0;
    end else if (cell_last) begin
      acc_q     <= '0;
      err_value <= sum;
      err_valid <= rd_en;
    end else begin
      acc_q     <= sum;
      err_valid <= 1'b0;
    end
  end

  assert_err_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (int'(err_value) >= -HALF_SLOTS && int'(err_value) <= 2 * HALF_SLOTS))
    else $error("per-cell error out of range");
endmodule

// File: rtl/pd_data_phase_det.sv
`timescale 1ns/1ps
module pd_data_phase_det
  import pd_pkg::*;
#(
  parameter int  HALF_SLOTS  = 4,
  parameter int  SYNC_STAGES = 2,
  localparam int ERR_W       = $clog2(2 * HALF_SLOTS) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    raw_data,
  input  logic                    rd_en,
  input  logic                    ref_up,
  input  logic                    ref_dn,
  output logic                    pump_up,
  output logic                    pump_dn,
  output logic                    rclk,
  output logic                    err_valid,
  output logic signed [ERR_W-1:0] err_value
);
  pd_tick_t tick;
  logic     data_rise, up_now, dn_now;

  pd_phase_gen #(.HALF_SLOTS(HALF_SLOTS)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rclk(rclk)
  );

  pd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_data), .rise(data_rise)
  );

  pd_pulse_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .data_rise(data_rise), .tick(tick),
    .rclk(rclk), .up_now(up_now), .dn_now(dn_now)
  );

  pd_error_acc #(.HALF_SLOTS(HALF_SLOTS), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .up_now(up_now), .dn_now(dn_now),
    .cell_last(tick.last), .rd_en(rd_en),
    .err_valid(err_valid), .err_value(err_value)
  );

  // Mode multiplexer, registered so the pump pins are glitch free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else if (rd_en) begin
      pump_up <= up_now;
      pump_dn <= dn_now;
    end else begin
      pump_up <= ref_up;
      pump_dn <= ref_dn;
    end
  end

  assert_valid_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> rclk) else $error("error reported away from slot 0");

  assert_ref_mode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(rd_en)) else $error("error reported in reference mode");
endmodule

// File: tb/pd_data_phase_det_tb_top.sv
`timescale 1ns/1ps
module pd_data_phase_det_tb_top;
  localparam int HS   = 4;
  localparam int CELL = 2 * HS;
  localparam int EW   = $clog2(CELL) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_data = 1'b0, rd_en = 1'b0, ref_up = 1'b0, ref_dn = 1'b0;
  logic pump_up, pump_dn, rclk, err_valid;
  logic signed [EW-1:0] err_value;

  always #2.5 clk = ~clk;

  pd_data_phase_det #(.HALF_SLOTS(HS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .rd_en(rd_en),
    .ref_up(ref_up), .ref_dn(ref_dn), .pump_up(pump_up), .pump_dn(pump_dn),
    .rclk(rclk), .err_valid(err_valid), .err_value(err_value)
  );

  typedef struct {
    bit    v;
    int    err;
    int    up;
    int    dn;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0, n_fail = 0, stray = 0;
  bit   done = 1'b0, mon_on = 1'b0, pend = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: counts pump slots per cell and compares at each slot 0.
  int  c_up = 0, c_dn = 0, c_clk = 0;
  logic prev_rclk = 1'b1;
  always @(negedge clk) begin
    if (mon_on) begin
      c_up  += int'(pump_up);
      c_dn  += int'(pump_dn);
      c_clk += int'(rclk);
      if (!prev_rclk && rclk) begin
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(err_valid == e.v, e.tag, "err_valid", int'(err_valid), int'(e.v));
          if (e.v) chk(int'(err_value) == e.err, e.tag, "err_value", int'(err_value), e.err);
          chk(c_up == e.up, e.tag, "pump_up slots", c_up, e.up);
          chk(c_dn == e.dn, e.tag, "pump_dn slots", c_dn, e.dn);
          chk(c_clk == HS, "R2", "rclk high slots", c_clk, HS);
        end
        c_up = 0; c_dn = 0; c_clk = 0;
      end else if (err_valid) begin
        stray++;
      end
      prev_rclk = rclk;
    end
  end

  // Driver: one call per cell, entered and left at the slot-0 sample.
  // kind: 0 idle, 1 rising pulse at slot p, 2 rise at p and hold, 3 drop at p.
  task automatic do_cell(input int kind, input int p, input bit mode_on,
                         input int ref_sel, input int ref_q, input int ref_k,
                         input string tag);
    exp_t e;
    bit   has_edge;
    int   up_det, dn_det;
    has_edge = (kind == 1 || kind == 2);
    rd_en = mode_on;
    up_det = has_edge ? CELL - p : 0;
    dn_det = (pend || (has_edge && p <= HS)) ? HS : 0;
    for (int s = 0; s < CELL; s++) begin
      if (has_edge && s == p - 2) raw_data = 1'b1;
      if ((kind == 1 || kind == 3) && s == p) raw_data = 1'b0;
      if (ref_sel == 1) ref_up = (s >= ref_q && s < ref_q + ref_k);
      if (ref_sel == 2) ref_dn = (s >= ref_q && s < ref_q + ref_k);
      if (s == CELL - 1) begin
        e.v   = mode_on;
        e.err = up_det - dn_det;
        e.up  = mode_on ? up_det : ((ref_sel == 1) ? ref_k : 0);
        e.dn  = mode_on ? dn_det : ((ref_sel == 2) ? ref_k : 0);
        e.tag = tag;
        sb_q.push_back(e);
        pend = has_edge && (p > HS);
      end
      @(negedge clk);
    end
    ref_up = 1'b0;
    ref_dn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pump_up == 1'b0, "R1", "pump_up in reset", int'(pump_up), 0);
    chk(pump_dn == 1'b0, "R1", "pump_dn in reset", int'(pump_dn), 0);
    chk(err_valid == 1'b0, "R1", "err_valid in reset", int'(err_valid), 0);
    chk(rclk == 1'b1, "R1", "rclk in reset", int'(rclk), 1);
    rst_n = 1'b1;
    rd_en = 1'b1;
    mon_on = 1'b1;
    // align to slot 0: rclk rises when the counter wraps
    do @(negedge clk); while (rclk !== 1'b0);
    do @(negedge clk); while (rclk !== 1'b1);

    do_cell(0, 0, 1, 0, 0, 0, "R6 idle cell");
    do_cell(1, 4, 1, 0, 0, 0, "R7 edge at mid cell");
    do_cell(1, 2, 1, 0, 0, 0, "R3 R5 R7 early edge");
    do_cell(0, 0, 1, 0, 0, 0, "R6 idle after edge");
    do_cell(1, 7, 1, 0, 0, 0, "R3 R5 late edge");
    do_cell(0, 0, 1, 0, 0, 0, "R5 deferred down");
    do_cell(1, 5, 1, 0, 0, 0, "R5 late edge arms");
    do_cell(1, 3, 1, 0, 0, 0, "R9 merged arm");
    do_cell(0, 0, 1, 0, 0, 0, "R9 no second down");
    do_cell(2, 6, 1, 0, 0, 0, "R3 rise and hold");
    do_cell(3, 3, 1, 0, 0, 0, "R4 falling data");
    do_cell(0, 0, 1, 0, 0, 0, "R4 quiet after fall");
    do_cell(1, 3, 0, 1, 1, 3, "R8 ref up");
    do_cell(0, 0, 0, 2, 2, 4, "R8 ref down");
    do_cell(0, 0, 1, 0, 0, 0, "R8 back to data");
    do_cell(1, 6, 1, 0, 0, 0, "R3 edge at slot 6");
    do_cell(0, 0, 1, 0, 0, 0, "R5 deferred down 2");
    repeat (CELL + 2) @(negedge clk);
    chk(sb_q.size() == 0, "R7", "unchecked cells", sb_q.size(), 0);
    chk(stray == 0, "R7", "valid away from slot 0", stray, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule